// File: doc/BRIEF.md
# Always-On Power Sequencer

This block is a state machine on the always-on kilohertz clock. It brings the main power domain and the fast clocks up and down. It talks to an analog power/clock controller through request/acknowledge levels and drives the isolation control. Once the main domain is up, it hands control to the fast-domain sequencer through a level request/acknowledge pair.

The fast sequencer asks for low power with its own request level. The block then gates each clock and removes main power only as a software-written snapshot directs. It reports that low power has been reached, and waits there for an enabled wake or reset request.

Every asynchronous input passes through a synchronizer chain before the state machine uses it. The low-power configuration, wake enables and reset enables cross into this domain only when software raises a sync request. The block answers that request with a level acknowledge once the values are captured, and the requesting side clears its bit on that acknowledge.

Top module: `aon_pwr_seq`

## Requirements
- R1: While `rstN` is low: `mainPdN`=0, `coreClkEn`=`ioClkEn`=`usbClkEn`=0, `isoEn`=1, `fastPwrUpReq`=0, `fastPwrDnAck`=0 and `cfgSyncAck`=0.
- R2: Power-up runs in a fixed order, and each step waits for the previous acknowledge after SyncStages synchronizer flops:
  - `mainPdN` rises first.
  - All three clock enables rise SyncStages+1 cycles later.
  - `isoEn` falls SyncStages+1 cycles after that.
  - `fastPwrUpReq` rises one cycle after `isoEn` falls.
  - No clock enable rises while `mainPdN` is 0, and `fastPwrUpReq` is never high while `isoEn` is 1.
- R3: Once `fastPwrUpAck` is returned, the block rests in its active idle state. It holds `mainPdN`=1, all clock enables at 1, `isoEn`=0 and `fastPwrUpReq`=1 for as long as no power-down request arrives.
- R4: On `fastPwrDnReq`, the block does the following in order:
  - It drops `fastPwrUpReq`.
  - It sets the core, IO and USB clock enables to the snapshot bits.
  - After the clock acknowledges match, it asserts `isoEn`.
  - It sets `mainPdN` to the snapshot bit.
  - After the main acknowledge matches and `fastPwrUpAck` is low, it raises `fastPwrDnAck`.
  - `fastPwrDnAck` and `fastPwrUpReq` are never high together, and `mainPdN` falls only while `isoEn` is 1.
- R5: The snapshot main-domain bit is active low: 0 powers the domain down in low power, and 1 keeps `mainPdN` at 1.
- R6: In low power, a wake bit that is high and enabled in the wake-enable snapshot drops `fastPwrDnAck` and starts the R2 power-up.
- R7: In low power, an enabled reset request starts the same power-up even when no wakeup arrived.
- R8: In low power, wake and reset bits whose enable snapshot bit is 0 have no effect: `fastPwrDnAck` stays 1 and the power outputs keep their low-power values.
- R9: Outside low power, wake and reset requests are ignored. An enabled reset request in the active idle state leaves every output unchanged.
- R10: The configuration inputs are captured only on a sync request:
  - A synchronized high `cfgSyncReq` captures the configuration inputs and raises `cfgSyncAck`.
  - `cfgSyncAck` falls after `cfgSyncReq` falls.
  - A configuration input changed without a sync does not affect the next low-power entry.
  - `cfgSyncAck` is still 0 one cycle after `cfgSyncReq` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rstN | input | 1 | Power-on reset, active low |
| cfgSyncReq | input | 1 | Software configuration sync request level |
| cfgCoreClkEn | input | 1 | Core clock kept on in low power |
| cfgIoClkEn | input | 1 | IO clock kept on in low power |
| cfgUsbClkEn | input | 1 | USB clock kept on in low power |
| cfgMainPdN | input | 1 | Main domain kept powered in low power (0 = power down) |
| cfgWakeEn | input | NumWake | Wake request enables |
| cfgResetEn | input | NumRst | Reset request enables |
| cfgSyncAck | output | 1 | Configuration captured acknowledge |
| wakeReq | input | NumWake | Wake request levels |
| resetReq | input | NumRst | Reset request levels |
| ackMainPwr | input | 1 | Analog main power state acknowledge |
| ackCoreClk | input | 1 | Analog core clock state acknowledge |
| ackIoClk | input | 1 | Analog IO clock state acknowledge |
| ackUsbClk | input | 1 | Analog USB clock state acknowledge |
| mainPdN | output | 1 | Main power request, 1 = powered |
| coreClkEn | output | 1 | Core clock enable request |
| ioClkEn | output | 1 | IO clock enable request |
| usbClkEn | output | 1 | USB clock enable request |
| isoEn | output | 1 | Isolation control, 1 = isolated |
| fastPwrUpReq | output | 1 | Power-up request to fast sequencer |
| fastPwrUpAck | input | 1 | Fast sequencer power-up acknowledge |
| fastPwrDnReq | input | 1 | Fast sequencer low-power request |
| fastPwrDnAck | output | 1 | Low power reached acknowledge |

## Verification
The assertions watch several orderings on every cycle:
- no clock enable rises while main power is off;
- the power-up request is never raised while isolation is on;
- main power never falls without isolation;
- the low-power acknowledge and the power-up request are never high together;
- the configuration snapshot changes only together with a new sync acknowledge;
- the machine stays in its resting states without a cause.

The bench scenarios show what a per-cycle property cannot:
- the exact gap between power-up steps;
- that each low-power configuration reaches the right outputs;
- that only enabled wake or reset bits end low power;
- that an unsynced configuration change is not used.

// File: rtl/aon_pwr_pkg.sv
package aon_pwr_pkg;

  typedef enum logic [3:0] {
    StReset,
    StMainOn,
    StClkOn,
    StIsoOff,
    StFastUp,
    StIdle,
    StClkOff,
    StIsoOn,
    StMainOff,
    StLowPower
  } seqState_e;

  typedef struct packed {
    logic mainOn;
    logic mainCfg;
    logic clkOn;
    logic clkCfg;
    logic isoOn;
    logic isoOff;
    logic upReqSet;
    logic upReqClr;
    logic dnAckSet;
    logic dnAckClr;
  } seqStrobe_t;

  typedef struct packed {
    logic mainAckOk;
    logic clkAckOk;
    logic fastUpAckS;
    logic fastDnReqS;
    logic wakeHit;
    logic rstHit;
  } seqStatus_t;

  typedef struct packed {
    logic coreClkEn;
    logic ioClkEn;
    logic usbClkEn;
    logic mainPdN;
  } lpCfg_t;

endpackage

// File: rtl/aon_sync.sv
module aon_sync #(
  parameter int Width  = 1,
  parameter int Stages = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] din,
  output logic [Width-1:0] dout
);

  logic [Stages-1:0][Width-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[Stages-2:0], din};
  end

  assign dout = pipe[Stages-1];

endmodule

// File: rtl/aon_pwr_dp.sv
module aon_pwr_dp
  import aon_pwr_pkg::*;
#(
  parameter int NumWake    = 4,
  parameter int NumRst     = 2,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  output seqStatus_t         status,
  input  logic               cfgSyncReq,
  input  lpCfg_t             cfgIn,
  input  logic [NumWake-1:0] cfgWakeEn,
  input  logic [NumRst-1:0]  cfgResetEn,
  output logic               cfgSyncAck,
  input  logic [NumWake-1:0] wakeReq,
  input  logic [NumRst-1:0]  resetReq,
  input  logic               ackMainPwr,
  input  logic               ackCoreClk,
  input  logic               ackIoClk,
  input  logic               ackUsbClk,
  input  logic               fastPwrUpAck,
  input  logic               fastPwrDnReq,
  output logic               mainPdN,
  output logic               coreClkEn,
  output logic               ioClkEn,
  output logic               usbClkEn,
  output logic               isoEn,
  output logic               fastPwrUpReq,
  output logic               fastPwrDnAck
);

  localparam int SyncW = 7 + NumWake + NumRst;

  logic [SyncW-1:0]   rawIn, syncOut;
  logic               syncReqS, upAckS, dnReqS, mainAckS, coreAckS, ioAckS, usbAckS;
  logic [NumWake-1:0] wakeS, wakeEnSnap;
  logic [NumRst-1:0]  rstS, rstEnSnap;
  lpCfg_t             cfgSnap;

  assign rawIn = {cfgSyncReq, fastPwrUpAck, fastPwrDnReq, ackMainPwr,
                  ackCoreClk, ackIoClk, ackUsbClk, wakeReq, resetReq};

  aon_sync #(.Width(SyncW), .Stages(SyncStages)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (rawIn),
    .dout (syncOut)
  );

  assign {syncReqS, upAckS, dnReqS, mainAckS, coreAckS, ioAckS, usbAckS,
          wakeS, rstS} = syncOut;

  // Configuration snapshot: captured once per sync request level
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSnap    <= '{coreClkEn: 1'b0, ioClkEn: 1'b0, usbClkEn: 1'b0, mainPdN: 1'b1};
      wakeEnSnap <= '0;
      rstEnSnap  <= '0;
      cfgSyncAck <= 1'b0;
    end else if (syncReqS && !cfgSyncAck) begin
      cfgSnap    <= cfgIn;
      wakeEnSnap <= cfgWakeEn;
      rstEnSnap  <= cfgResetEn;
      cfgSyncAck <= 1'b1;
    end else if (!syncReqS) begin
      cfgSyncAck <= 1'b0;
    end
  end

  // Power, clock, isolation and handshake request registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mainPdN      <= 1'b0;
      coreClkEn    <= 1'b0;
      ioClkEn      <= 1'b0;
      usbClkEn     <= 1'b0;
      isoEn        <= 1'b1;
      fastPwrUpReq <= 1'b0;
      fastPwrDnAck <= 1'b0;
    end else begin
      if (strobe.mainOn)       mainPdN <= 1'b1;
      else if (strobe.mainCfg) mainPdN <= cfgSnap.mainPdN;
      if (strobe.clkOn) begin
        {coreClkEn, ioClkEn, usbClkEn} <= 3'b111;
      end else if (strobe.clkCfg) begin
        {coreClkEn, ioClkEn, usbClkEn} <= {cfgSnap.coreClkEn, cfgSnap.ioClkEn, cfgSnap.usbClkEn};
      end
      if (strobe.isoOn)         isoEn <= 1'b1;
      else if (strobe.isoOff)   isoEn <= 1'b0;
      if (strobe.upReqSet)      fastPwrUpReq <= 1'b1;
      else if (strobe.upReqClr) fastPwrUpReq <= 1'b0;
      if (strobe.dnAckSet)      fastPwrDnAck <= 1'b1;
      else if (strobe.dnAckClr) fastPwrDnAck <= 1'b0;
    end
  end

  assign status.mainAckOk  = (mainAckS == mainPdN);
  assign status.clkAckOk   = ({coreAckS, ioAckS, usbAckS} == {coreClkEn, ioClkEn, usbClkEn});
  assign status.fastUpAckS = upAckS;
  assign status.fastDnReqS = dnReqS;
  assign status.wakeHit    = |(wakeS & wakeEnSnap);
  assign status.rstHit     = |(rstS & rstEnSnap);

  AST_CLK_NEEDS_MAIN: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(coreClkEn) || $rose(ioClkEn) || $rose(usbClkEn)) |-> mainPdN) else $error("AST_CLK_NEEDS_MAIN"); // R2
  AST_UPREQ_UNISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    fastPwrUpReq |-> !isoEn) else $error("AST_UPREQ_UNISOLATED"); // R2
  AST_MAIN_OFF_ISOLATED: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mainPdN) |-> isoEn) else $error("AST_MAIN_OFF_ISOLATED"); // R4
  AST_DNACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    fastPwrDnAck |-> !fastPwrUpReq) else $error("AST_DNACK_EXCLUSIVE"); // R4
  AST_SNAP_ONLY_ON_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgSnap) |-> $rose(cfgSyncAck)) else $error("AST_SNAP_ONLY_ON_SYNC"); // R10

endmodule

// File: rtl/aon_pwr_ctrl.sv
module aon_pwr_ctrl
  import aon_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  seqStatus_t status,
  output seqStrobe_t strobe
);

  seqState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      StReset: begin
        strobe.mainOn = 1'b1;
        stateD        = StMainOn;
      end
      StMainOn: if (status.mainAckOk) begin
        strobe.clkOn = 1'b1;
        stateD       = StClkOn;
      end
      StClkOn: if (status.clkAckOk) begin
        strobe.isoOff = 1'b1;
        stateD        = StIsoOff;
      end
      StIsoOff: begin
        strobe.upReqSet = 1'b1;
        stateD          = StFastUp;
      end
      StFastUp: if (status.fastUpAckS) stateD = StIdle;
      StIdle: if (status.fastDnReqS) begin
        strobe.upReqClr = 1'b1;
        strobe.clkCfg   = 1'b1;
        stateD          = StClkOff;
      end
      StClkOff: if (status.clkAckOk) begin
        strobe.isoOn = 1'b1;
        stateD       = StIsoOn;
      end
      StIsoOn: begin
        strobe.mainCfg = 1'b1;
        stateD         = StMainOff;
      end
      StMainOff: if (status.mainAckOk && !status.fastUpAckS) begin
        strobe.dnAckSet = 1'b1;
        stateD          = StLowPower;
      end
      StLowPower: if (status.wakeHit || status.rstHit) begin
        strobe.dnAckClr = 1'b1;
        strobe.mainOn   = 1'b1;
        stateD          = StMainOn;
      end
      default: stateD = StReset;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= StReset;
    else       stateQ <= stateD;
  end

  AST_LP_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == StLowPower && !status.wakeHit && !status.rstHit) |=> stateQ == StLowPower)
    else $error("AST_LP_NEEDS_CAUSE"); // R8
  AST_IDLE_RESTS: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == StIdle && !status.fastDnReqS) |=> stateQ == StIdle)
    else $error("AST_IDLE_RESTS"); // R9

endmodule

// File: rtl/aon_pwr_seq.sv
module aon_pwr_seq
  import aon_pwr_pkg::*;
#(
  parameter int NumWake    = 4,
  parameter int NumRst     = 2,
  parameter int SyncStages = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgSyncReq,
  input  logic               cfgCoreClkEn,
  input  logic               cfgIoClkEn,
  input  logic               cfgUsbClkEn,
  input  logic               cfgMainPdN,
  input  logic [NumWake-1:0] cfgWakeEn,
  input  logic [NumRst-1:0]  cfgResetEn,
  output logic               cfgSyncAck,
  input  logic [NumWake-1:0] wakeReq,
  input  logic [NumRst-1:0]  resetReq,
  input  logic               ackMainPwr,
  input  logic               ackCoreClk,
  input  logic               ackIoClk,
  input  logic               ackUsbClk,
  output logic               mainPdN,
  output logic               coreClkEn,
  output logic               ioClkEn,
  output logic               usbClkEn,
  output logic               isoEn,
  output logic               fastPwrUpReq,
  input  logic               fastPwrUpAck,
  input  logic               fastPwrDnReq,
  output logic               fastPwrDnAck
);

  seqStrobe_t strobe;
  seqStatus_t status;
  lpCfg_t     cfgIn;

  assign cfgIn = '{coreClkEn: cfgCoreClkEn, ioClkEn: cfgIoClkEn,
                   usbClkEn: cfgUsbClkEn, mainPdN: cfgMainPdN};

  aon_pwr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe)
  );

  aon_pwr_dp #(.NumWake(NumWake), .NumRst(NumRst), .SyncStages(SyncStages)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .status       (status),
    .cfgSyncReq   (cfgSyncReq),
    .cfgIn        (cfgIn),
    .cfgWakeEn    (cfgWakeEn),
    .cfgResetEn   (cfgResetEn),
    .cfgSyncAck   (cfgSyncAck),
    .wakeReq      (wakeReq),
    .resetReq     (resetReq),
    .ackMainPwr   (ackMainPwr),
    .ackCoreClk   (ackCoreClk),
    .ackIoClk     (ackIoClk),
    .ackUsbClk    (ackUsbClk),
    .fastPwrUpAck (fastPwrUpAck),
    .fastPwrDnReq (fastPwrDnReq),
    .mainPdN      (mainPdN),
    .coreClkEn    (coreClkEn),
    .ioClkEn      (ioClkEn),
    .usbClkEn     (usbClkEn),
    .isoEn        (isoEn),
    .fastPwrUpReq (fastPwrUpReq),
    .fastPwrDnAck (fastPwrDnAck)
  );

endmodule

// File: tb/aon_pwr_seq_tb.sv
module aon_pwr_seq_tb;

  localparam int NumWake    = 4;
  localparam int NumRst     = 2;
  localparam int SyncStages = 2;
  localparam int StepGap    = SyncStages + 1;
  // low-power vectors: {core, io, usb, mainPdN}
  localparam logic [3:0] LpVec [4] = '{4'b0000, 4'b0001, 4'b1101, 4'b0110};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgSyncReq = 1'b0, cfgCoreClkEn = 1'b0, cfgIoClkEn = 1'b0, cfgUsbClkEn = 1'b0, cfgMainPdN = 1'b1;
  logic [NumWake-1:0] cfgWakeEn = '0, wakeReq = '0;
  logic [NumRst-1:0]  cfgResetEn = '0, resetReq = '0;
  logic fastPwrDnReq = 1'b0;
  logic cfgSyncAck, mainPdN, coreClkEn, ioClkEn, usbClkEn, isoEn, fastPwrUpReq, fastPwrDnAck;
  logic ackMainPwr, ackCoreClk, ackIoClk, ackUsbClk, fastPwrUpAck;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  // analog controller and fast sequencer models: acknowledge levels follow requests
  assign ackMainPwr   = mainPdN;
  assign ackCoreClk   = coreClkEn;
  assign ackIoClk     = ioClkEn;
  assign ackUsbClk    = usbClkEn;
  assign fastPwrUpAck = fastPwrUpReq;

  aon_pwr_seq #(.NumWake(NumWake), .NumRst(NumRst), .SyncStages(SyncStages)) u_dut (
    .clk(clk), .rstN(rstN), .cfgSyncReq(cfgSyncReq), .cfgCoreClkEn(cfgCoreClkEn),
    .cfgIoClkEn(cfgIoClkEn), .cfgUsbClkEn(cfgUsbClkEn), .cfgMainPdN(cfgMainPdN),
    .cfgWakeEn(cfgWakeEn), .cfgResetEn(cfgResetEn), .cfgSyncAck(cfgSyncAck),
    .wakeReq(wakeReq), .resetReq(resetReq), .ackMainPwr(ackMainPwr),
    .ackCoreClk(ackCoreClk), .ackIoClk(ackIoClk), .ackUsbClk(ackUsbClk),
    .mainPdN(mainPdN), .coreClkEn(coreClkEn), .ioClkEn(ioClkEn), .usbClkEn(usbClkEn),
    .isoEn(isoEn), .fastPwrUpReq(fastPwrUpReq), .fastPwrUpAck(fastPwrUpAck),
    .fastPwrDnReq(fastPwrDnReq), .fastPwrDnAck(fastPwrDnAck)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic syncCfg(input logic [3:0] v, input logic [NumWake-1:0] we, input logic [NumRst-1:0] re);
    {cfgCoreClkEn, cfgIoClkEn, cfgUsbClkEn, cfgMainPdN} = v;
    cfgWakeEn  = we;
    cfgResetEn = re;
    @(negedge clk);
    cfgSyncReq = 1'b1;
    @(negedge clk);
    check("R10 ack not before sync", {31'b0, cfgSyncAck}, 32'd0);
    for (int i = 0; i < 20 && !cfgSyncAck; i++) @(negedge clk);
    check("R10 ack raised", {31'b0, cfgSyncAck}, 32'd1);
    cfgSyncReq = 1'b0;
    for (int i = 0; i < 20 && cfgSyncAck; i++) @(negedge clk);
    check("R10 ack cleared", {31'b0, cfgSyncAck}, 32'd0);
  endtask

  task automatic enterLp(input logic [3:0] exp, input string tag);
    fastPwrDnReq = 1'b1;
    for (int i = 0; i < 200 && !fastPwrDnAck; i++) @(negedge clk);
    check({tag, " dnAck"}, {31'b0, fastPwrDnAck}, 32'd1);
    check({tag, " lp outputs"}, {28'b0, coreClkEn, ioClkEn, usbClkEn, mainPdN}, {28'b0, exp});
    check({tag, " iso/upReq"}, {30'b0, isoEn, fastPwrUpReq}, 32'b10);
    fastPwrDnReq = 1'b0;
  endtask

  task automatic expectActive(input string tag);
    for (int i = 0; i < 200 && !fastPwrUpReq; i++) @(negedge clk);
    check({tag, " active outputs"},
          {25'b0, mainPdN, coreClkEn, ioClkEn, usbClkEn, isoEn, fastPwrUpReq, fastPwrDnAck},
          32'b1111010);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    int tMain, tClk, tIso, tUp;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outputs",
          {24'b0, mainPdN, coreClkEn, ioClkEn, usbClkEn, isoEn, fastPwrUpReq, fastPwrDnAck, cfgSyncAck},
          32'b00001000);
    rstN = 1'b1;
    // R2 power-up order and spacing
    tMain = -1; tClk = -1; tIso = -1; tUp = -1;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (tMain < 0 && mainPdN) tMain = c;
      if (tClk < 0 && coreClkEn && ioClkEn && usbClkEn) tClk = c;
      if (tIso < 0 && !isoEn) tIso = c;
      if (tUp < 0 && fastPwrUpReq) tUp = c;
    end
    check("R2 main to clocks gap", tClk - tMain, StepGap);
    check("R2 clocks to iso gap", tIso - tClk, StepGap);
    check("R2 iso to upReq gap", tUp - tIso, 1);
    // R3 resting active state
    check("R3 idle outputs",
          {26'b0, mainPdN, coreClkEn, ioClkEn, usbClkEn, isoEn, fastPwrUpReq},
          32'b111101);

    // table walk: R4/R5 entry, R6 exit by wake, R7 exit by reset
    for (int k = 0; k < 4; k++) begin
      syncCfg(LpVec[k], '1, '1);
      enterLp(LpVec[k], "R4 R5 vector");
      repeat (4) @(negedge clk);
      if (k % 2 == 0) begin
        wakeReq[k % NumWake] = 1'b1;
        expectActive("R6 wake exit");
        wakeReq = '0;
      end else begin
        resetReq[k % NumRst] = 1'b1;
        expectActive("R7 reset exit");
        resetReq = '0;
      end
    end

    // R8 masked requests ignored in low power
    syncCfg(4'b0000, 4'b0001, 2'b01);
    enterLp(4'b0000, "R8 entry");
    wakeReq  = 4'b0100;
    resetReq = 2'b10;
    repeat (20) @(negedge clk);
    check("R8 masked stay low",
          {29'b0, fastPwrDnAck, mainPdN, fastPwrUpReq}, 32'b100);
    wakeReq  = 4'b0001;
    resetReq = '0;
    expectActive("R8 enabled bit exits");
    wakeReq = '0;

    // R9 enabled reset in idle is ignored
    resetReq = 2'b01;
    repeat (20) @(negedge clk);
    check("R9 idle unchanged",
          {25'b0, mainPdN, coreClkEn, ioClkEn, usbClkEn, isoEn, fastPwrUpReq, fastPwrDnAck},
          32'b1111010);
    resetReq = '0;
    repeat (4) @(negedge clk);

    // R10 unsynced change not used: snapshot keeps main on
    syncCfg(4'b0001, '1, '0);
    cfgMainPdN   = 1'b0;
    cfgCoreClkEn = 1'b1;
    enterLp(4'b0001, "R10 unsynced cfg");
    wakeReq = 4'b0010;
    expectActive("R6 wake after R10");
    wakeReq = '0;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule